// File: doc/BRIEF.md
# Receive Overhead Data-Link Extraction Port

This block sits next to a T1/E1 receive framer. It picks the data-link overhead bits out of the recovered line bit stream and sends them out on a two-wire serial port: a pulse clock and a data line. The framer supplies a bit strobe and position markers for each line bit: frame number, timeslot, bit index within the timeslot, and a flag that marks a frame-alignment-signal (FAS) frame. It also supplies an alignment-valid flag. A mode input chooses between DS1 extended-superframe (ESF) operation and E1 operation. An 8-bit configuration byte chooses which overhead bits are tapped.

In ESF mode, the data link is carried in the framing-bit position of the odd frames of a 24-frame superframe. The port can tap all of those bits, or every other one with either of two phases. In E1 mode, any subset of the five national bits Sa4 to Sa8 in timeslot 0 of non-FAS frames can be tapped. Each tapped bit produces one clock pulse of fixed width. The data line changes only as that pulse rises and keeps its value until the next tapped bit, so a receiver can latch it on the falling edge.

Top module: `ovh_dl_port`

## Requirements
- R1: A synchronous active-high reset `rst` drives `ovh_clk` and `ovh_dat` low on the next clock edge and keeps them low while it is held. A reset that arrives in the middle of a pulse cuts that pulse short.
- R2: ESF mode (`mode_e1`=0) with bandwidth code `cfg[1:0]`=00 taps the framing-bit position of every odd frame. The framing-bit position is marked by `tslot`=0 and `bit_idx`=0, and `frame_num` counts 1 to 24. This gives 12 pulses per superframe.
- R3: Bandwidth code 01 taps only frames 1, 5, 9, 13, 17 and 21, giving 6 pulses per superframe.
- R4: Bandwidth code 10 taps only frames 3, 7, 11, 15, 19 and 23, giving 6 pulses per superframe.
- R5: Bandwidth code 11 is reserved and taps nothing. `ovh_clk` stays low and `ovh_dat` keeps its last value.
- R6: One cycle after the strobe of a tapped bit, `ovh_clk` rises and `ovh_dat` takes that bit's `rx_bit` value. `ovh_dat` changes at no other time.
- R7: E1 mode (`mode_e1`=1) taps the national bits at `tslot`=0, `bit_idx` 3 to 7, of non-FAS frames (`fas_frame`=0). `bit_idx` 0 is the first bit of the timeslot, so index 3 is Sa4 and index 7 is Sa8. Sa8 down to Sa4 are enabled by `cfg[7]` down to `cfg[3]`, so the enable for index k is `cfg[k]`.
- R8: In E1 mode, FAS frames, other bit positions and disabled national bits produce no pulse. With all enables clear, a multiframe gives 0 pulses.
- R9: Each pulse is high for exactly HI_CYC clock cycles (default 2) and then low until the next tapped bit. The bit strobe must be spaced more than HI_CYC cycles apart.
- R10: While `in_frame` is low, no pulse starts and `ovh_dat` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe marking a valid line bit |
| rx_bit | input | 1 | Recovered line bit |
| mode_e1 | input | 1 | 0 = DS1 ESF, 1 = E1 |
| in_frame | input | 1 | Framer alignment valid |
| frame_num | input | FNW (5) | Frame number within superframe/multiframe |
| tslot | input | TSW (5) | Timeslot index |
| bit_idx | input | 3 | Bit index in timeslot, 0 = first |
| fas_frame | input | 1 | Current E1 frame carries the FAS |
| cfg | input | 8 | [7:3] Sa8..Sa4 enables, [1:0] ESF bandwidth code |
| ovh_clk | output | 1 | Overhead port clock pulse |
| ovh_dat | output | 1 | Overhead port data |

## Verification
Every result is registered once. The pulse rise and the new data bit appear at the first clock edge after the strobe cycle, and the pulse falls HI_CYC edges after that. The bench drives inputs on the falling edge. It advances a behavioural reference model on each rising edge from the same inputs, and compares both outputs on every falling edge, so the check always lands one edge after the cause. Pulse counts per superframe or multiframe are taken over whole frame walks, with each strobe followed by enough idle cycles for the pulse to finish.

// File: rtl/ovh_pkg.sv
package ovh_pkg;
   // ESF data-link bandwidth codes (cfg[1:0])
   typedef enum logic [1:0] {
      BW_FULL  = 2'b00,
      BW_PH1   = 2'b01,
      BW_PH3   = 2'b10,
      BW_RSVD  = 2'b11
   } bw_code_t;

   localparam int SA_COUNT   = 5;   // Sa4..Sa8
   localparam int SA_FIRST   = 3;   // bit index of Sa4 in timeslot 0
   localparam int FBIT_TSLOT = 0;
   localparam int FBIT_INDEX = 0;
endpackage

// File: rtl/ovh_esf_sel.sv
module ovh_esf_sel
   import ovh_pkg::*;
#(
   parameter int FNW = 5,
   parameter int TSW = 5
) (
   input  logic [FNW-1:0] frame_num,
   input  logic [TSW-1:0] tslot,
   input  logic [2:0]     bit_idx,
   input  logic [1:0]     bw,
   output logic           hit
);
   logic at_fbit;
   logic odd_frame;
   logic phase_ok;

   if (FNW < 5) begin : g_bad_fnw
      $error("ovh_esf_sel: FNW must hold frame numbers up to 24");
   end

   assign at_fbit   = (tslot == TSW'(FBIT_TSLOT)) && (bit_idx == 3'(FBIT_INDEX));
   assign odd_frame = frame_num[0];

   always_comb begin
      unique case (bw_code_t'(bw))
         BW_FULL: phase_ok = 1'b1;
         BW_PH1:  phase_ok = (frame_num[1] == 1'b0);  // 1,5,9,...
         BW_PH3:  phase_ok = (frame_num[1] == 1'b1);  // 3,7,11,...
         default: phase_ok = 1'b0;                    // reserved
      endcase
   end

   assign hit = at_fbit && odd_frame && phase_ok;
endmodule

// File: rtl/ovh_e1_sel.sv
module ovh_e1_sel
   import ovh_pkg::*;
#(
   parameter int TSW = 5
) (
   input  logic [TSW-1:0]      tslot,
   input  logic [2:0]          bit_idx,
   input  logic                fas_frame,
   input  logic [SA_COUNT-1:0] sa_en,     // [0]=Sa4 ... [4]=Sa8
   output logic                hit
);
   logic [SA_COUNT-1:0] sa_hit;

   for (genvar k = 0; k < SA_COUNT; k++) begin : g_sa
      assign sa_hit[k] = sa_en[k] && (bit_idx == 3'(SA_FIRST + k));
   end

   assign hit = (tslot == '0) && !fas_frame && (|sa_hit);
endmodule

// File: rtl/ovh_pulse_gen.sv
module ovh_pulse_gen #(
   parameter int HI_CYC = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic fire,
   output logic pulse
);
   localparam int CW = (HI_CYC < 2) ? 1 : $clog2(HI_CYC);

   logic [CW-1:0] cnt;

   if (HI_CYC < 1) begin : g_bad_hi
      $error("ovh_pulse_gen: HI_CYC must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt   <= '0;
         pulse <= 1'b0;
      end else if (fire) begin
         cnt   <= CW'(HI_CYC - 1);
         pulse <= 1'b1;
      end else if (cnt != '0) begin
         cnt   <= cnt - 1'b1;
      end else begin
         pulse <= 1'b0;
      end
   end

   // width checker: cycles high since the last fire
   logic [CW:0] run;
   always_ff @(posedge clk) begin
      if (rst)        run <= '0;
      else if (fire)  run <= '0;
      else if (pulse) run <= run + 1'b1;
   end

   a_r9_pulse_width: assert property (@(posedge clk) disable iff (rst)
      ($fell(pulse) && !$past(rst)) |-> (run == (CW+1)'(HI_CYC)))
      else $error("R9 pulse width differs from HI_CYC");
endmodule

// File: rtl/ovh_dl_port.sv
module ovh_dl_port
   import ovh_pkg::*;
#(
   parameter int FNW    = 5,
   parameter int TSW    = 5,
   parameter int HI_CYC = 2
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           bit_en,
   input  logic           rx_bit,
   input  logic           mode_e1,
   input  logic           in_frame,
   input  logic [FNW-1:0] frame_num,
   input  logic [TSW-1:0] tslot,
   input  logic [2:0]     bit_idx,
   input  logic           fas_frame,
   input  logic [7:0]     cfg,
   output logic           ovh_clk,
   output logic           ovh_dat
);
   logic esf_hit, e1_hit, sel_hit, fire;
   logic unused_cfg2;

   assign unused_cfg2 = cfg[2];

   ovh_esf_sel #(.FNW(FNW), .TSW(TSW)) u_esf (
      .frame_num (frame_num),
      .tslot     (tslot),
      .bit_idx   (bit_idx),
      .bw        (cfg[1:0]),
      .hit       (esf_hit)
   );

   ovh_e1_sel #(.TSW(TSW)) u_e1 (
      .tslot     (tslot),
      .bit_idx   (bit_idx),
      .fas_frame (fas_frame),
      .sa_en     (cfg[7:3]),
      .hit       (e1_hit)
   );

   assign sel_hit = mode_e1 ? e1_hit : esf_hit;
   assign fire    = bit_en && in_frame && sel_hit;

   always_ff @(posedge clk) begin
      if (rst)       ovh_dat <= 1'b0;
      else if (fire) ovh_dat <= rx_bit;
   end

   ovh_pulse_gen #(.HI_CYC(HI_CYC)) u_pulse (
      .clk   (clk),
      .rst   (rst),
      .fire  (fire),
      .pulse (ovh_clk)
   );

   a_r10_rise_needs_align: assert property (@(posedge clk) disable iff (rst)
      $rose(ovh_clk) |-> $past(bit_en && in_frame))
      else $error("R10 pulse without aligned strobe");

   a_r5_rsvd_silent: assert property (@(posedge clk) disable iff (rst)
      ($rose(ovh_clk) && $past(!mode_e1)) |-> $past(cfg[1:0] != 2'b11))
      else $error("R5 pulse under reserved bandwidth code");

   a_r8_no_fas_tap: assert property (@(posedge clk) disable iff (rst)
      ($rose(ovh_clk) && $past(mode_e1)) |-> $past(!fas_frame && tslot == '0))
      else $error("R8 pulse from FAS frame or wrong slot");

   a_r6_data_stable_high: assert property (@(posedge clk) disable iff (rst)
      (ovh_clk && $past(ovh_clk) && !$rose(ovh_clk)) |-> $stable(ovh_dat))
      else $error("R6 data moved while clock high");
endmodule

// File: tb/sim_ovh_dl_port.sv
`timescale 1ns/1ps
module sim_ovh_dl_port;
   localparam int HI  = 2;
   localparam int GAP = 5;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic bit_en = 1'b0, rx_bit = 1'b0, mode_e1 = 1'b0, in_frame = 1'b1;
   logic [4:0] frame_num = '0;
   logic [4:0] tslot = '0;
   logic [2:0] bit_idx = '0;
   logic fas_frame = 1'b0;
   logic [7:0] cfg = '0;
   logic ovh_clk, ovh_dat;

   always #2.5 clk = ~clk;   // 200 MHz

   ovh_dl_port #(.FNW(5), .TSW(5), .HI_CYC(HI)) u0 (
      .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit), .mode_e1(mode_e1),
      .in_frame(in_frame), .frame_num(frame_num), .tslot(tslot), .bit_idx(bit_idx),
      .fas_frame(fas_frame), .cfg(cfg), .ovh_clk(ovh_clk), .ovh_dat(ovh_dat));

   int errors = 0, checks = 0;
   string cur_req = "R1";
   bit started = 0;
   int hi_left = 0;
   logic exp_clk = 1'b0, exp_dat = 1'b0;
   logic prev_clk = 1'b0;
   int pulses = 0;
   int unsigned seed = 32'h1234_5678;

   function automatic bit ref_sel();
      int fr = int'(frame_num);
      if (!mode_e1)
         return (tslot == 0) && (bit_idx == 0) && (fr % 2 == 1) &&
                ((cfg[1:0] == 2'b00) || (cfg[1:0] == 2'b01 && fr % 4 == 1) ||
                 (cfg[1:0] == 2'b10 && fr % 4 == 3));
      return (tslot == 0) && !fas_frame && bit_idx >= 3 && cfg[bit_idx];
   endfunction

   // reference model
   always @(posedge clk) begin
      started <= 1'b1;
      if (rst) begin
         hi_left = 0; exp_dat = 1'b0;
      end else if (bit_en && in_frame && ref_sel()) begin
         hi_left = HI; exp_dat = rx_bit;
      end else if (hi_left > 0) begin
         hi_left--;
      end
      exp_clk = (hi_left > 0);
   end

   task automatic check(string req, int act, int exp, string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // per-cycle compare, away from the active edge
   always @(negedge clk) if (started) begin
      checks++;
      if (ovh_clk !== exp_clk || ovh_dat !== exp_dat) begin
         errors++;
         $display("FAIL %s per-cycle: actual clk=%b dat=%b expected clk=%b dat=%b",
                  cur_req, ovh_clk, ovh_dat, exp_clk, exp_dat);
      end
      if (ovh_clk === 1'b1 && prev_clk !== 1'b1) pulses++;
      prev_clk = ovh_clk;
   end

   task automatic strobe(int fr, int ts, int bi, bit fas);
      @(negedge clk);
      seed = seed * 1103515245 + 12345;
      frame_num = 5'(fr); tslot = 5'(ts); bit_idx = 3'(bi); fas_frame = fas;
      rx_bit = seed[9]; bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      repeat (GAP) @(negedge clk);
   endtask

   task automatic esf_superframe();
      for (int f = 1; f <= 24; f++) begin
         strobe(f, 0, 0, 1'b0);
         strobe(f, 0, 1, 1'b0);
         strobe(f, 3, 0, 1'b0);
      end
   endtask

   task automatic e1_multiframe();
      for (int f = 0; f < 16; f++) begin
         for (int b = 0; b < 8; b++) strobe(f, 0, b, (f % 2) == 0);
         strobe(f, 1, 3, (f % 2) == 0);
         strobe(f, 1, 7, (f % 2) == 0);
      end
   endtask

   initial begin
      logic held;
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", ovh_clk, 0, "clk in reset");
      check("R1", ovh_dat, 0, "dat in reset");
      rst = 1'b0;

      cur_req = "R2"; cfg = 8'h00; pulses = 0; esf_superframe();
      check("R2", pulses, 12, "ESF full-rate pulses");
      check("R9", ovh_clk, 0, "clk low between bits");

      cur_req = "R3"; cfg = 8'h01; pulses = 0; esf_superframe();
      check("R3", pulses, 6, "ESF phase-1 pulses");

      cur_req = "R4"; cfg = 8'h02; pulses = 0; esf_superframe();
      check("R4", pulses, 6, "ESF phase-3 pulses");

      cur_req = "R5"; held = ovh_dat; cfg = 8'h03; pulses = 0; esf_superframe();
      check("R5", pulses, 0, "reserved code pulses");
      check("R5", ovh_dat, held, "dat held under reserved code");

      cur_req = "R7"; mode_e1 = 1'b1; cfg = 8'hF8; pulses = 0; e1_multiframe();
      check("R7", pulses, 40, "E1 all Sa enabled pulses");
      cur_req = "R7"; cfg = 8'h8B; pulses = 0; e1_multiframe();
      check("R7", pulses, 16, "E1 Sa8+Sa4 pulses");
      cur_req = "R8"; cfg = 8'h07; pulses = 0; e1_multiframe();
      check("R8", pulses, 0, "E1 no enables pulses");

      cur_req = "R10"; mode_e1 = 1'b0; cfg = 8'h00; in_frame = 1'b0;
      held = ovh_dat; pulses = 0; esf_superframe();
      check("R10", pulses, 0, "pulses out of alignment");
      check("R10", ovh_dat, held, "dat held out of alignment");
      in_frame = 1'b1;

      // R6: data follows tapped bit one cycle after strobe
      cur_req = "R6";
      @(negedge clk);
      frame_num = 5'd1; tslot = '0; bit_idx = '0; rx_bit = ~ovh_dat; bit_en = 1'b1;
      held = rx_bit;
      @(negedge clk); bit_en = 1'b0;
      check("R6", ovh_clk, 1, "clk rises one cycle after strobe");
      check("R6", ovh_dat, held, "dat takes tapped bit");
      // R1: reset mid-pulse
      cur_req = "R1"; rst = 1'b1;
      @(negedge clk);
      check("R1", ovh_clk, 0, "reset cuts pulse");
      check("R1", ovh_dat, 0, "reset clears dat");
      rst = 1'b0;
      repeat (4) @(negedge clk);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule